// File: doc/BRIEF.md
# Three-Wide Dispatch Allocator

This block sits between the head of an instruction queue and the execution units. Each cycle it looks at up to three queued instructions in program order. It partially decodes each one to learn whether it is a branch, and for any other instruction which of four unit types should take it. It then decides how many of the three can leave the queue that cycle. The instruction queue advances its head pointer by the returned dispatch count.

Every non-branch instruction that dispatches reserves one rename register and one completion-queue entry. A branch reserves a completion-queue entry only when it updates the link or count register. Both pools are held as free counters. Dispatches decrement them, release counts from retirement increment them, and a misprediction flush reloads them from values supplied with the flush. The flush also suppresses all dispatch in that cycle.

Top module: `dispatch_alloc3`

## Requirements
- R1: Opcode decode works as follows. A slot whose opcode bits [5:3] equal 3'b111 is a branch. Any other opcode is steered to the unit numbered by opcode bits [5:4]: 0 integer, 1 load/store, 2 floating point, 3 system. `disp_unit_o` for a slot shows that unit number when the slot dispatches a non-branch, and shows 0 otherwise.
- R2: At most two non-branch instructions dispatch per cycle. A third dispatch happens only when one of the three dispatched instructions is a branch.
- R3: Dispatch is in program order. Once a slot does not dispatch, no later slot dispatches in that cycle. `disp_cnt_o` equals the number of set bits in `disp_vld_o`.
- R4: A non-branch dispatches only if three conditions hold: its unit's ready bit is set, a rename register is still free after the earlier slots' reservations, and a completion entry is still free after those reservations.
- R5: A branch takes no rename register and ignores unit ready. It needs a free completion entry only if opcode bit 0 (link update) or bit 1 (count update) is set.
- R6: After reset the free counts equal the pool depths. In each cycle without a flush, the next free count is the current count, minus this cycle's allocation, plus this cycle's release input.
- R7: While `flush_i` is high, nothing dispatches and both allocation counts are 0. On the next cycle the free counts equal the flush values, and release inputs in the flush cycle have no effect.
- R8: A slot whose valid bit is low never dispatches and blocks all later slots.
- R9: `ren_alloc_o` and `cq_alloc_o` equal the number of rename registers and completion entries reserved by this cycle's dispatched instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld_i | input | 3 | Valid bit per queue-head slot, bit 0 is oldest |
| slot_op_i | input | 3x6 | Opcode field per slot |
| unit_rdy_i | input | 4 | Ready bit per execution unit type |
| ren_rel_i | input | 2 | Rename registers released this cycle |
| cq_rel_i | input | 2 | Completion entries released this cycle |
| flush_i | input | 1 | Misprediction flush |
| flush_ren_free_i | input | 4 | Rename free count to restore on flush |
| flush_cq_free_i | input | 3 | Completion free count to restore on flush |
| disp_vld_o | output | 3 | Slot dispatched this cycle |
| disp_unit_o | output | 3x2 | Target unit per dispatched non-branch slot |
| disp_cnt_o | output | 2 | Number of instructions dispatched |
| ren_alloc_o | output | 2 | Rename registers reserved this cycle |
| cq_alloc_o | output | 2 | Completion entries reserved this cycle |
| ren_free_o | output | 4 | Current rename free count |
| cq_free_o | output | 3 | Current completion free count |

## Verification
The only state in the block is the pair of free counters. When a counter is wrong, the visible free count diverges on the cycle after the bad update. Dispatch decisions then shift: a group either stalls too early or over-commits the pool. The reference model therefore compares both free counts and all dispatch outputs on every cycle. It also drives long runs that drain each pool to zero, so that off-by-one errors at the empty boundary show up at once. Flushes arrive at random points with arbitrary restore values, which exposes any leakage of release counts into the flush cycle.

// File: rtl/dispatch_alloc_pkg.sv
package dispatch_alloc_pkg;
    localparam int OP_W      = 6;
    localparam int NUM_UNITS = 4;
    localparam int UNIT_W    = $clog2(NUM_UNITS);
    localparam int LINK_BIT  = 0;
    localparam int COUNT_BIT = 1;
    localparam logic [2:0] BRANCH_CLASS = 3'b111;

    typedef struct packed {
        logic              is_br;
        logic              needs_ren;
        logic              needs_cq;
        logic [UNIT_W-1:0] unit;
    } slot_info_t;
endpackage

// File: rtl/dsp_slot_decode.sv
module dsp_slot_decode
    import dispatch_alloc_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output slot_info_t      info_o
);
    logic is_br;

    always_comb begin
        is_br            = (op_i[OP_W-1 -: 3] == BRANCH_CLASS);
        info_o.is_br     = is_br;
        info_o.needs_ren = !is_br;
        info_o.needs_cq  = !is_br || op_i[LINK_BIT] || op_i[COUNT_BIT];
        info_o.unit      = is_br ? '0 : op_i[OP_W-1 -: UNIT_W];
    end
endmodule

// File: rtl/dsp_free_pool.sv
module dsp_free_pool #(
    parameter int DEPTH   = 8,
    parameter int CW      = $clog2(DEPTH + 1),
    parameter int ALLOC_W = 2,
    parameter int REL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ALLOC_W-1:0] alloc_i,
    input  logic [REL_W-1:0]   rel_i,
    input  logic               flush_i,
    input  logic [CW-1:0]      flush_val_i,
    output logic [CW-1:0]      free_o
);
    localparam int SW = CW + 2;

    typedef struct packed {
        logic [CW-1:0] free;
    } pool_state_t;

    pool_state_t st_d, st_q;
    logic [SW-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = SW'(st_q.free) - SW'(alloc_i) + SW'(rel_i);
        if (flush_i) st_d.free = flush_val_i;
        else         st_d.free = CW'(sum);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.free <= CW'(DEPTH);
        else        st_q      <= st_d;
    end

    assign free_o = st_q.free;

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        free_o <= CW'(DEPTH));
    assert_alloc_within_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        SW'(alloc_i) <= SW'(free_o));
    assert_free_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i |=> free_o == CW'(SW'($past(free_o)) - SW'($past(alloc_i)) + SW'($past(rel_i))));
    assert_flush_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> free_o == $past(flush_val_i));
endmodule

// File: rtl/dsp_group_select.sv
module dsp_group_select
    import dispatch_alloc_pkg::*;
#(
    parameter int NUM_SLOTS = 3,
    parameter int REN_CW    = 4,
    parameter int CQ_CW     = 3,
    parameter int ALLOC_W   = $clog2(NUM_SLOTS + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  slot_info_t [NUM_SLOTS-1:0]        info_i,
    input  logic [NUM_SLOTS-1:0]              vld_i,
    input  logic [NUM_UNITS-1:0]              unit_rdy_i,
    input  logic [REN_CW-1:0]                 ren_free_i,
    input  logic [CQ_CW-1:0]                  cq_free_i,
    input  logic                              flush_i,
    output logic [NUM_SLOTS-1:0]              disp_vld_o,
    output logic [NUM_SLOTS-1:0][UNIT_W-1:0]  disp_unit_o,
    output logic [ALLOC_W-1:0]                disp_cnt_o,
    output logic [ALLOC_W-1:0]                ren_alloc_o,
    output logic [ALLOC_W-1:0]                cq_alloc_o
);
    localparam int MAX_NB = NUM_SLOTS - 1;

    logic [NUM_SLOTS-1:0] br_mask;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_mask
        assign br_mask[g] = info_i[g].is_br;
    end

    always_comb begin
        logic               stop;
        logic               go;
        logic [ALLOC_W-1:0] nb;
        logic [ALLOC_W-1:0] cnt;
        logic [REN_CW-1:0]  ru;
        logic [CQ_CW-1:0]   cu;
        stop        = flush_i;
        nb          = '0;
        cnt         = '0;
        ru          = '0;
        cu          = '0;
        disp_vld_o  = '0;
        disp_unit_o = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            go = 1'b0;
            if (!stop && vld_i[i]) begin
                if (info_i[i].is_br)
                    go = !info_i[i].needs_cq || (cu < cq_free_i);
                else
                    go = (nb < ALLOC_W'(MAX_NB)) && unit_rdy_i[info_i[i].unit]
                         && (ru < ren_free_i) && (cu < cq_free_i);
            end
            if (go) begin
                disp_vld_o[i] = 1'b1;
                cnt = cnt + ALLOC_W'(1);
                if (!info_i[i].is_br) begin
                    disp_unit_o[i] = info_i[i].unit;
                    nb = nb + ALLOC_W'(1);
                end
                if (info_i[i].needs_ren) ru = ru + REN_CW'(1);
                if (info_i[i].needs_cq)  cu = cu + CQ_CW'(1);
            end else begin
                stop = 1'b1;
            end
        end
        disp_cnt_o  = cnt;
        ren_alloc_o = ALLOC_W'(ru);
        cq_alloc_o  = ALLOC_W'(cu);
    end

    assert_nonbranch_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(disp_vld_o & ~br_mask) <= MAX_NB);
    assert_in_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((disp_vld_o >> 1) & ~disp_vld_o) == '0);
    assert_count_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(disp_vld_o) == int'(disp_cnt_o));
    assert_invalid_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_vld_o & ~vld_i) == '0);
    assert_flush_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> (disp_vld_o == '0 && ren_alloc_o == '0 && cq_alloc_o == '0));
    assert_ren_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        REN_CW'(ren_alloc_o) <= ren_free_i);
    assert_cq_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        CQ_CW'(cq_alloc_o) <= cq_free_i);
endmodule

// File: rtl/dispatch_alloc3.sv
module dispatch_alloc3
    import dispatch_alloc_pkg::*;
#(
    parameter int NUM_SLOTS = 3,
    parameter int REN_DEPTH = 8,
    parameter int CQ_DEPTH  = 6,
    parameter int REL_W     = 2,
    localparam int REN_CW   = $clog2(REN_DEPTH + 1),
    localparam int CQ_CW    = $clog2(CQ_DEPTH + 1),
    localparam int ALLOC_W  = $clog2(NUM_SLOTS + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SLOTS-1:0]              slot_vld_i,
    input  logic [NUM_SLOTS-1:0][OP_W-1:0]    slot_op_i,
    input  logic [NUM_UNITS-1:0]              unit_rdy_i,
    input  logic [REL_W-1:0]                  ren_rel_i,
    input  logic [REL_W-1:0]                  cq_rel_i,
    input  logic                              flush_i,
    input  logic [REN_CW-1:0]                 flush_ren_free_i,
    input  logic [CQ_CW-1:0]                  flush_cq_free_i,
    output logic [NUM_SLOTS-1:0]              disp_vld_o,
    output logic [NUM_SLOTS-1:0][UNIT_W-1:0]  disp_unit_o,
    output logic [ALLOC_W-1:0]                disp_cnt_o,
    output logic [ALLOC_W-1:0]                ren_alloc_o,
    output logic [ALLOC_W-1:0]                cq_alloc_o,
    output logic [REN_CW-1:0]                 ren_free_o,
    output logic [CQ_CW-1:0]                  cq_free_o
);
    slot_info_t [NUM_SLOTS-1:0] info;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dec
        dsp_slot_decode u_dec (
            .op_i   (slot_op_i[s]),
            .info_o (info[s])
        );
    end

    dsp_group_select #(
        .NUM_SLOTS (NUM_SLOTS),
        .REN_CW    (REN_CW),
        .CQ_CW     (CQ_CW),
        .ALLOC_W   (ALLOC_W)
    ) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .info_i      (info),
        .vld_i       (slot_vld_i),
        .unit_rdy_i  (unit_rdy_i),
        .ren_free_i  (ren_free_o),
        .cq_free_i   (cq_free_o),
        .flush_i     (flush_i),
        .disp_vld_o  (disp_vld_o),
        .disp_unit_o (disp_unit_o),
        .disp_cnt_o  (disp_cnt_o),
        .ren_alloc_o (ren_alloc_o),
        .cq_alloc_o  (cq_alloc_o)
    );

    dsp_free_pool #(
        .DEPTH (REN_DEPTH), .CW (REN_CW), .ALLOC_W (ALLOC_W), .REL_W (REL_W)
    ) u_ren_pool (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_i     (ren_alloc_o),
        .rel_i       (ren_rel_i),
        .flush_i     (flush_i),
        .flush_val_i (flush_ren_free_i),
        .free_o      (ren_free_o)
    );

    dsp_free_pool #(
        .DEPTH (CQ_DEPTH), .CW (CQ_CW), .ALLOC_W (ALLOC_W), .REL_W (REL_W)
    ) u_cq_pool (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_i     (cq_alloc_o),
        .rel_i       (cq_rel_i),
        .flush_i     (flush_i),
        .flush_val_i (flush_cq_free_i),
        .free_o      (cq_free_o)
    );

    assert_branch_no_unit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_vld_o[0] && slot_op_i[0][OP_W-1 -: 3] == BRANCH_CLASS) |-> disp_unit_o[0] == '0);
    assert_ren_le_cq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ren_alloc_o <= cq_alloc_o);
endmodule

// File: tb/tb_dispatch_alloc3.sv
module tb_dispatch_alloc3;
    localparam int REN_D = 8;
    localparam int CQ_D  = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      slot_vld = '0;
    logic [2:0][5:0] slot_op = '0;
    logic [3:0]      unit_rdy = '0;
    logic [1:0]      ren_rel = '0, cq_rel = '0;
    logic            flush = 1'b0;
    logic [3:0]      fl_ren = '0;
    logic [2:0]      fl_cq = '0;
    logic [2:0]      d_vld;
    logic [2:0][1:0] d_unit;
    logic [1:0]      d_cnt, r_alloc, c_alloc;
    logic [3:0]      r_free;
    logic [2:0]      c_free;

    int checks = 0, fails = 0;
    int m_ren = REN_D, m_cq = CQ_D;
    bit done = 0;

    always #5 clk = ~clk;

    dispatch_alloc3 dut (
        .clk(clk), .rst_n(rst_n), .slot_vld_i(slot_vld), .slot_op_i(slot_op),
        .unit_rdy_i(unit_rdy), .ren_rel_i(ren_rel), .cq_rel_i(cq_rel), .flush_i(flush),
        .flush_ren_free_i(fl_ren), .flush_cq_free_i(fl_cq), .disp_vld_o(d_vld),
        .disp_unit_o(d_unit), .disp_cnt_o(d_cnt), .ren_alloc_o(r_alloc),
        .cq_alloc_o(c_alloc), .ren_free_o(r_free), .cq_free_o(c_free)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(string tag, logic [2:0] v, logic [5:0] o0, logic [5:0] o1,
                        logic [5:0] o2, logic [3:0] rdy, int rr, int cr,
                        bit fl, int fr, int fc);
        int e_vld[3];
        int e_unit[3];
        int cnt, nb, ru, cu;
        bit stop;
        @(posedge clk); #1;
        slot_vld = v; slot_op[0] = o0; slot_op[1] = o1; slot_op[2] = o2;
        unit_rdy = rdy; ren_rel = 2'(rr); cq_rel = 2'(cr);
        flush = fl; fl_ren = 4'(fr); fl_cq = 3'(fc);
        @(negedge clk);
        cnt = 0; nb = 0; ru = 0; cu = 0; stop = fl;
        for (int i = 0; i < 3; i++) begin
            bit br, ok, wcq;
            e_vld[i] = 0; e_unit[i] = 0;
            br  = (slot_op[i][5:3] == 3'b111);
            wcq = !br || slot_op[i][0] || slot_op[i][1];
            ok  = 0;
            if (!stop && v[i]) begin
                if (br) ok = !wcq || (cu < m_cq);
                else    ok = (nb < 2) && rdy[slot_op[i][5:4]] && (ru < m_ren) && (cu < m_cq);
            end
            if (ok) begin
                e_vld[i] = 1; cnt++;
                if (!br) begin e_unit[i] = slot_op[i][5:4]; nb++; ru++; end
                if (wcq) cu++;
            end else stop = 1;
        end
        chk(tag, "R6 ren_free", r_free, m_ren);
        chk(tag, "R6 cq_free", c_free, m_cq);
        for (int i = 0; i < 3; i++) begin
            chk(tag, "R3 disp_vld", d_vld[i], e_vld[i]);
            chk(tag, "R1 disp_unit", d_unit[i], e_unit[i]);
        end
        chk(tag, "R3 disp_cnt", d_cnt, cnt);
        chk(tag, "R9 ren_alloc", r_alloc, ru);
        chk(tag, "R9 cq_alloc", c_alloc, cu);
        if (fl) begin m_ren = fr; m_cq = fc; end
        else begin m_ren = m_ren - ru + rr; m_cq = m_cq - cu + cr; end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    localparam logic [5:0] ALU = 6'b000000, LSU = 6'b010000, FPU = 6'b100000,
                           SYS = 6'b110000, BR = 6'b111000, BRL = 6'b111001,
                           BRC = 6'b111010;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step("R6 reset", 3'b000, ALU, ALU, ALU, 4'hF, 0, 0, 0, 0, 0);
        step("R2 three non-branch", 3'b111, ALU, LSU, FPU, 4'hF, 0, 0, 0, 0, 0);
        step("R2 branch third", 3'b111, ALU, SYS, BR, 4'hF, 2, 2, 0, 0, 0);
        step("R5 link branch", 3'b111, BRL, ALU, LSU, 4'hF, 0, 0, 0, 0, 0);
        step("R5 count branch", 3'b111, BRC, BR, ALU, 4'h0, 0, 0, 0, 0, 0);
        step("R4 unit busy slot0", 3'b111, FPU, ALU, BR, 4'b1011, 0, 0, 0, 0, 0);
        step("R3 unit busy slot1", 3'b111, ALU, FPU, BR, 4'b1011, 0, 0, 0, 0, 0);
        step("R8 invalid slot0", 3'b110, ALU, ALU, BR, 4'hF, 0, 0, 0, 0, 0);
        step("R7 flush", 3'b111, ALU, BR, ALU, 4'hF, 3, 3, 1, 2, 1);
        step("R4 pool nearly empty", 3'b111, ALU, ALU, BRL, 4'hF, 0, 0, 0, 0, 0);
        step("R4 cq empty", 3'b111, BRL, ALU, BR, 4'hF, 0, 0, 0, 0, 0);
        step("R5 plain branch empty cq", 3'b111, BR, BR, BR, 4'hF, 0, 0, 0, 0, 0);
        step("R7 restore full", 3'b000, ALU, ALU, ALU, 4'hF, 0, 0, 1, REN_D, CQ_D);
        step("R1 system unit", 3'b011, SYS, LSU, ALU, 4'hF, 0, 0, 0, 0, 0);
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] o[3];
            int rr, cr, frr, fcc;
            bit fl;
            for (int k = 0; k < 3; k++) begin
                o[k] = 6'($urandom);
                if ($urandom_range(3) == 0) o[k][5:3] = 3'b111;
            end
            rr  = $urandom_range(3); if (rr > REN_D - m_ren) rr = REN_D - m_ren;
            cr  = $urandom_range(3); if (cr > CQ_D - m_cq)  cr = CQ_D - m_cq;
            if ($urandom_range(3) == 0) begin rr = 0; cr = 0; end
            fl  = ($urandom_range(40) == 0);
            frr = $urandom_range(REN_D);
            fcc = $urandom_range(CQ_D);
            step("R9 random", 3'($urandom), o[0], o[1], o[2], 4'($urandom | 4'h5),
                 rr, cr, fl, frr, fcc);
        end
        done = 1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule